// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers fifteen one-cycle event pulses raised by a serial-bus controller. Each pulse is recorded in a sticky status register, but only if the host has set the matching bit in a mask register. The status register has the same bit layout as the mask. Its top bit, which the mask leaves unused, carries a master flag that is set whenever any recorded cause is pending. A host can therefore find out why an interrupt fired with a single read. The same summary drives an active-high interrupt request pin.

The host uses a small register port: a word-select input, a write strobe, a read strobe, write data and combinational read data. Offset 00h holds the mask, which can be read and written. Offset 06h holds the status word, which is read-only. Reading the status word clears every recorded cause. A pulse that arrives in the same cycle as that read is not lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask and the status word read as 0000h and irqOut is low.
- R2: A write to offset 00h loads wrData bits 14..0 into the mask. A mask read at offset 00h returns those bits, with bit 15 always reading 0.
- R3: An event pulse on bit i with mask bit i set is recorded in status bit i at the next clock edge. It stays recorded until a status read clears it.
- R4: An event pulse on bit i with mask bit i clear is not recorded.
- R5: A status read at offset 06h returns the recorded causes in bits 14..0. Bit 15 is the master flag, which is 1 if any of bits 14..0 is 1.
- R6: A status read clears all recorded causes at the clock edge that ends the read cycle.
- R7: An enabled event pulse in the same cycle as a status read is recorded after the clear, so the next status read reports it.
- R8: irqOut is high exactly while at least one cause is recorded.
- R9: When a mask write and an event pulse fall in the same cycle, the pulse is judged against the mask value from before the write.
- R10: Clearing a mask bit does not remove a cause that is already recorded.
- R11: Writes to any offset other than 00h have no effect. Reads of offsets other than 00h and 06h return 0000h.
- R12: A mask read (offset 00h) does not clear the recorded causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| eventPulse | input | 15 | One-cycle cause pulses, bit i maps to mask/status bit i |
| regSel | input | 5 | Register word offset |
| wrEn | input | 1 | Write strobe for the selected register |
| rdEn | input | 1 | Read strobe for the selected register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register while rdEn is high, else 0 |
| irqOut | output | 1 | Interrupt request, active high, follows the master flag |

## Verification
Two pairs of actions can fall in the same clock cycle. The first is a status read, which clears the word, together with a fresh enabled pulse. The bench raises a pulse during the read cycle and requires the read to return only the older causes, while the following read returns the new one. The second is a mask write together with a pulse. The bench drives both in one cycle, in both directions (enabling and disabling a bit), and checks that the pre-write mask decided whether the pulse was kept.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int EVT_W  = 15;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic loadMask;
    logic clearStatus;
    logic selMask;
    logic selStatus;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_stat_ctl.sv
module irq_stat_ctl
  import irq_stat_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] MASK_OFS = 'h00,
  parameter logic [AW-1:0] STAT_OFS = 'h06
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regSel,
  input  logic          wrEn,
  input  logic          rdEn,
  output ctlStrobe_t    strobes
);
  logic hitMask, hitStat;

  assign hitMask = (regSel == MASK_OFS);
  assign hitStat = (regSel == STAT_OFS);

  always_comb begin
    strobes             = '0;
    strobes.loadMask    = wrEn & hitMask;
    strobes.selMask     = rdEn & hitMask;
    strobes.selStatus   = rdEn & hitStat;
    strobes.clearStatus = rdEn & hitStat;
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selMask, strobes.selStatus})); // R11
  AST_NO_CLR_ON_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selMask |-> !strobes.clearStatus); // R12
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobes,
  input  logic [EW-1:0] eventPulse,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          masterFlag
);
  localparam int PAD_W = DW - EW - 1;

  logic [EW-1:0] maskReg;
  logic [EW-1:0] statusReg;
  logic [EW-1:0] hitVec;
  logic          unusedWrHi;

  assign unusedWrHi = ^wrData[DW-1:EW];
  assign hitVec     = eventPulse & maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 maskReg <= '0;
    else if (strobes.loadMask) maskReg <= wrData[EW-1:0];
  end

  for (genvar i = 0; i < EW; i++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    statusReg[i] <= 1'b0;
      else if (strobes.clearStatus) statusReg[i] <= hitVec[i];
      else                          statusReg[i] <= statusReg[i] | hitVec[i];
    end
  end

  assign masterFlag = |statusReg;

  always_comb begin
    rdData = '0;
    if (strobes.selStatus) begin
      rdData = {masterFlag, {PAD_W{1'b0}}, statusReg};
    end else if (strobes.selMask) begin
      rdData = {1'b0, {PAD_W{1'b0}}, maskReg};
    end
  end

  AST_NO_UNMASKED_SET: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~$past(statusReg) & ~$past(maskReg)) == '0); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearStatus |=> ((statusReg & $past(statusReg)) == $past(statusReg))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearStatus && eventPulse == '0) |=> statusReg == '0); // R6
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  eventPulse,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  ctlStrobe_t strobes;
  logic       masterFlag;

  irq_stat_ctl #(.AW(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel),
    .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes)
  );

  irq_stat_dp #(.EW(EVT_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .eventPulse(eventPulse),
    .wrData(wrData), .rdData(rdData), .masterFlag(masterFlag)
  );

  assign irqOut = masterFlag;

  AST_MASTER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == ADDR_W'(6)) |-> (rdData[DATA_W-1] == irqOut)); // R5
  AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == ADDR_W'(0)) |-> !rdData[DATA_W-1]); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel != ADDR_W'(0) && regSel != ADDR_W'(6)) |-> rdData == '0); // R11
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] eventPulse = '0;
  logic [4:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse), .regSel(regSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %04h expected %04h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] ofs, input logic [15:0] v, input logic [14:0] ev);
    @(negedge clk);
    regSel = ofs; wrData = v; wrEn = 1'b1; eventPulse = ev;
    @(negedge clk);
    wrEn = 1'b0; eventPulse = '0;
  endtask

  task automatic readReg(input logic [4:0] ofs, input logic [14:0] ev, output logic [15:0] v);
    @(negedge clk);
    regSel = ofs; rdEn = 1'b1; eventPulse = ev;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0; eventPulse = '0;
  endtask

  task automatic pulse(input logic [14:0] ev);
    @(negedge clk);
    eventPulse = ev;
    @(negedge clk);
    eventPulse = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {15'd0, irqOut}, 16'h0000);
    readReg(5'h00, '0, v); check("R1 mask", v, 16'h0000);
    readReg(5'h06, '0, v); check("R1 status", v, 16'h0000);
  endtask

  task automatic t_maskRw();
    logic [15:0] v;
    writeReg(5'h00, 16'hFFFF, '0);
    readReg(5'h00, '0, v); check("R2 top bit", v, 16'h7FFF);
    writeReg(5'h00, 16'h1234, '0);
    readReg(5'h00, '0, v); check("R2 pattern", v, 16'h1234);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    writeReg(5'h00, 16'h7FFF, '0);
    pulse(15'h0005);
    check("R8 irq set", {15'd0, irqOut}, 16'h0001);
    pulse(15'h0000);
    check("R3 held irq", {15'd0, irqOut}, 16'h0001);
    readReg(5'h06, '0, v); check("R5 master+bits", v, 16'h8005);
    check("R8 irq clear", {15'd0, irqOut}, 16'h0000);
    readReg(5'h06, '0, v); check("R6 cleared", v, 16'h0000);
  endtask

  task automatic t_masked();
    logic [15:0] v;
    writeReg(5'h00, 16'h00F0, '0);
    pulse(15'h7F0F);
    check("R4 irq stays low", {15'd0, irqOut}, 16'h0000);
    readReg(5'h06, '0, v); check("R4 none", v, 16'h0000);
    pulse(15'h0F1F);
    readReg(5'h06, '0, v); check("R4 partial", v, 16'h8010);
  endtask

  task automatic t_readCollide();
    logic [15:0] v;
    writeReg(5'h00, 16'h7FFF, '0);
    pulse(15'h0001);
    readReg(5'h06, 15'h4000, v); check("R7 read old", v, 16'h8001);
    check("R7 irq kept", {15'd0, irqOut}, 16'h0001);
    readReg(5'h06, '0, v); check("R7 new kept", v, 16'hC000);
  endtask

  task automatic t_writeCollide();
    logic [15:0] v;
    writeReg(5'h00, 16'h0000, '0);
    writeReg(5'h00, 16'h0002, 15'h0003);
    readReg(5'h06, '0, v); check("R9 old mask off", v, 16'h0000);
    writeReg(5'h00, 16'h0000, 15'h0002);
    readReg(5'h06, '0, v); check("R9 old mask on", v, 16'h8002);
  endtask

  task automatic t_maskClearKeeps();
    logic [15:0] v;
    writeReg(5'h00, 16'h0100, '0);
    pulse(15'h0100);
    writeReg(5'h00, 16'h0000, '0);
    check("R10 irq", {15'd0, irqOut}, 16'h0001);
    readReg(5'h06, '0, v); check("R10 kept", v, 16'h8100);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    writeReg(5'h00, 16'h0008, '0);
    pulse(15'h0008);
    writeReg(5'h06, 16'h0000, '0);
    writeReg(5'h05, 16'h7FFF, '0);
    readReg(5'h00, '0, v); check("R11 mask unchanged", v, 16'h0008);
    check("R12 irq after mask read", {15'd0, irqOut}, 16'h0001);
    readReg(5'h1F, '0, v); check("R11 unmapped read", v, 16'h0000);
    readReg(5'h06, '0, v); check("R11 R12 status kept", v, 16'h8008);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_maskRw();
    t_latch();
    t_masked();
    t_readCollide();
    t_writeCollide();
    t_maskClearKeeps();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule